// File: doc/BRIEF.md
# Transmit Deferral Lock Controller

This block decides, cycle by cycle, whether a serial transmitter may start shifting out data from its transmit FIFO. Normally transmission begins as soon as the FIFO holds at least one byte. When deferral is switched on, the controller instead holds transmission back after the transmitter has run dry, until software has refilled the FIFO to a near-full level. Data written by the CPU in programmed I/O bursts therefore goes out back to back, and the transmitter does not run out of data halfway through a burst.

Deferral applies only when three conditions hold together: the deferral control bit is 1, the port runs in its extended mode, and the transmit FIFO is enabled. The release level depends on the FIFO depth in use. A 16-entry FIFO releases at a level of 14 and a 32-entry FIFO releases at a level of 30. Both values are the depth less a fixed headroom, and all of these figures are parameters. The FIFO storage and the serialiser are outside the block.

Top module: `txdefer_gate`

## Requirements
- R1: After reset the lock is clear. The permit `tx_start_ok` is then 1 exactly when `fifo_level` is nonzero.
- R2: Deferral is active only when `defer_en`, `ext_mode` and `fifo_on` are all 1. While it is inactive, `tx_start_ok` equals (`fifo_level` != 0) in the same cycle, whatever `tx_empty` does.
- R3: While deferral is active, a rising edge of `tx_empty` (0 in the previous cycle, 1 in this one) sets the lock at the next clock edge, unless the release level is already met in that cycle. While the lock is set and deferral stays active, `tx_start_ok` is 0.
- R4: With `depth_sel` = 0 (16-entry FIFO), a set lock is released at the clock edge after a cycle in which `fifo_level` >= 14. `tx_start_ok` rises in the following cycle, and never in the cycle where the level is first seen.
- R5: With `depth_sel` = 1 (32-entry FIFO), the release level is 30. A level from 14 to 29 leaves the lock set.
- R6: When deferral becomes inactive while the lock is set, `tx_start_ok` follows (`fifo_level` != 0) in that same cycle, and the lock is cleared at the next edge. Re-enabling deferral afterwards does not restore the lock.
- R7: `tx_start_ok` is never 1 while `fifo_level` is 0.
- R8: Once released, the lock stays clear while the FIFO drains, until the next rising edge of `tx_empty`.
- R9: A `tx_empty` held at 1 without a rising edge does not set the lock. This includes the case where deferral is switched on while the transmitter is already empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| defer_en | input | 1 | Deferral control bit, 1 enables deferral |
| ext_mode | input | 1 | Port runs in extended mode |
| fifo_on | input | 1 | Transmit FIFO is enabled |
| depth_sel | input | 1 | FIFO depth in use: 0 = 16 entries, 1 = 32 entries |
| fifo_level | input | LVL_W (6) | Number of bytes held in the transmit FIFO |
| tx_empty | input | 1 | Transmitter (shifter and FIFO) is empty |
| tx_start_ok | output | 1 | Transmitter may start or continue sending |

## Verification
The permit depends on the inputs without delay whenever deferral is inactive or the lock is clear. Each check therefore samples it a fraction of a cycle after the inputs change, still inside the same clock period. Setting and releasing the lock each take effect one clock edge after the cycle that triggers them. The reference model in the bench keeps its own lock state and updates it only at the rising edge, so a rising edge of `tx_empty` or a release level seen in cycle n first shows in the check of cycle n+1. Directed sequences check R4 and R5 at the exact cycles: the level reaches the threshold in cycle n, `tx_start_ok` must still be 0 in cycle n, and it must be 1 in cycle n+1.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

   typedef enum logic {
      DEPTH_SMALL = 1'b0,
      DEPTH_LARGE = 1'b1
   } depth_e;

   function automatic int unsigned release_level(input int unsigned depth,
                                                 input int unsigned headroom);
      return depth - headroom;
   endfunction

endpackage

// File: rtl/txdefer_thresh.sv
module txdefer_thresh
   import txdefer_pkg::*;
#(
   parameter int unsigned LVL_W       = 6,
   parameter int unsigned SMALL_DEPTH = 16,
   parameter int unsigned LARGE_DEPTH = 32,
   parameter int unsigned HEADROOM    = 2
) (
   input  logic             depth_sel,
   input  logic [LVL_W-1:0] fifo_level,
   output logic             level_met
);

   localparam int unsigned N_SEL = 2;
   localparam int unsigned DEPTHS [N_SEL] = '{SMALL_DEPTH, LARGE_DEPTH};

   logic [N_SEL-1:0] met_vec;

   for (genvar g = 0; g < N_SEL; g++) begin : g_cmp
      localparam int unsigned LIM = release_level(DEPTHS[g], HEADROOM);
      localparam logic [LVL_W-1:0] LIM_V = LVL_W'(LIM);
      assign met_vec[g] = (fifo_level >= LIM_V);
   end

   assign level_met = (depth_e'(depth_sel) == DEPTH_LARGE) ? met_vec[1] : met_vec[0];

endmodule

// File: rtl/txdefer_lock.sv
module txdefer_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tx_empty,
   input  logic level_met,
   output logic lock_q
);

   logic empty_q;
   logic empty_rise;
   logic lock_d;

   assign empty_rise = tx_empty & ~empty_q;

   always_comb begin
      lock_d = lock_q;
      if (!active) begin
         lock_d = 1'b0;
      end else if (level_met) begin
         lock_d = 1'b0;
      end else if (empty_rise) begin
         lock_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         empty_q <= tx_empty;
         lock_q  <= lock_d;
      end
   end

endmodule

// File: rtl/txdefer_gate.sv
module txdefer_gate
   import txdefer_pkg::*;
#(
   parameter int unsigned LVL_W       = 6,
   parameter int unsigned SMALL_DEPTH = 16,
   parameter int unsigned LARGE_DEPTH = 32,
   parameter int unsigned HEADROOM    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             defer_en,
   input  logic             ext_mode,
   input  logic             fifo_on,
   input  logic             depth_sel,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             tx_empty,
   output logic             tx_start_ok
);

   if (LARGE_DEPTH >= (1 << LVL_W)) begin : g_bad_width
      $error("txdefer_gate: LVL_W too narrow for LARGE_DEPTH");
   end
   if (SMALL_DEPTH >= LARGE_DEPTH) begin : g_bad_order
      $error("txdefer_gate: SMALL_DEPTH must be below LARGE_DEPTH");
   end
   if (HEADROOM == 0 || HEADROOM >= SMALL_DEPTH) begin : g_bad_head
      $error("txdefer_gate: HEADROOM out of range");
   end

   logic active;
   logic level_met;
   logic lock_q;
   logic has_data;

   assign active   = defer_en & ext_mode & fifo_on;
   assign has_data = (fifo_level != '0);

   txdefer_thresh #(
      .LVL_W       (LVL_W),
      .SMALL_DEPTH (SMALL_DEPTH),
      .LARGE_DEPTH (LARGE_DEPTH),
      .HEADROOM    (HEADROOM)
   ) i_thresh (
      .depth_sel  (depth_sel),
      .fifo_level (fifo_level),
      .level_met  (level_met)
   );

   txdefer_lock i_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .tx_empty  (tx_empty),
      .level_met (level_met),
      .lock_q    (lock_q)
   );

   assign tx_start_ok = has_data & ~(lock_q & active);

endmodule

// File: rtl/txdefer_chk.sv
module txdefer_chk #(
   parameter int unsigned LVL_W       = 6,
   parameter int unsigned SMALL_DEPTH = 16,
   parameter int unsigned LARGE_DEPTH = 32,
   parameter int unsigned HEADROOM    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             defer_en,
   input logic             ext_mode,
   input logic             fifo_on,
   input logic             depth_sel,
   input logic [LVL_W-1:0] fifo_level,
   input logic             tx_empty,
   input logic             tx_start_ok
);

   logic             on;
   logic [LVL_W-1:0] lim;
   logic             at_lim;

   assign on     = defer_en & ext_mode & fifo_on;
   assign lim    = depth_sel ? LVL_W'(LARGE_DEPTH - HEADROOM) : LVL_W'(SMALL_DEPTH - HEADROOM);
   assign at_lim = fifo_level >= lim;

   // R7
   no_idle_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_ok |-> (fifo_level != '0));

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !on |-> (tx_start_ok == (fifo_level != '0)));

   // R3
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on && $rose(tx_empty) && !at_lim) |=> (!on || !tx_start_ok));

   // R4
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on && !tx_start_ok && at_lim) |=> (tx_start_ok || fifo_level == '0));

   // R8
   stay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start_ok && !(on && tx_empty)) |=> (tx_start_ok || fifo_level == '0));

endmodule

bind txdefer_gate txdefer_chk #(
   .LVL_W       (LVL_W),
   .SMALL_DEPTH (SMALL_DEPTH),
   .LARGE_DEPTH (LARGE_DEPTH),
   .HEADROOM    (HEADROOM)
) i_txdefer_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .defer_en    (defer_en),
   .ext_mode    (ext_mode),
   .fifo_on     (fifo_on),
   .depth_sel   (depth_sel),
   .fifo_level  (fifo_level),
   .tx_empty    (tx_empty),
   .tx_start_ok (tx_start_ok)
);

// File: tb/test_txdefer_gate.sv
module test_txdefer_gate;

   localparam int LVL_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             defer_en = 1'b0;
   logic             ext_mode = 1'b0;
   logic             fifo_on = 1'b0;
   logic             depth_sel = 1'b0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic             tx_empty = 1'b0;
   logic             tx_start_ok;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state, updated only at rising edges
   bit m_lock = 1'b0;
   bit m_empty_q = 1'b0;

   always #4 clk = ~clk;

   txdefer_gate i_txdefer_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .defer_en    (defer_en),
      .ext_mode    (ext_mode),
      .fifo_on     (fifo_on),
      .depth_sel   (depth_sel),
      .fifo_level  (fifo_level),
      .tx_empty    (tx_empty),
      .tx_start_ok (tx_start_ok)
   );

   function automatic bit f_active();
      return defer_en && ext_mode && fifo_on;
   endfunction

   function automatic bit f_met();
      return depth_sel ? (fifo_level >= 30) : (fifo_level >= 14);
   endfunction

   function automatic bit f_permit();
      return (fifo_level != 0) && !(m_lock && f_active());
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lock    <= 1'b0;
         m_empty_q <= 1'b0;
      end else begin
         if (!f_active() || f_met()) m_lock <= 1'b0;
         else if (tx_empty && !m_empty_q) m_lock <= 1'b1;
         m_empty_q <= tx_empty;
      end
   end

   task automatic check(input bit exp, input string tag);
      checks++;
      if (tx_start_ok !== exp) begin
         failures++;
         $display("FAIL %s: tx_start_ok=%0b expected %0b (level=%0d act=%0b)",
                  tag, tx_start_ok, exp, fifo_level, f_active());
      end
   endtask

   function automatic string model_tag();
      if (!f_active()) return "R2";
      if (fifo_level == 0) return "R7";
      if (m_lock) return "R3";
      return "R8";
   endfunction

   task automatic drive(input bit en, input bit ext, input bit fon, input bit dsel,
                        input int lvl, input bit emp);
      @(negedge clk);
      defer_en = en; ext_mode = ext; fifo_on = fon; depth_sel = dsel;
      fifo_level = LVL_W'(lvl); tx_empty = emp;
      #1;
   endtask

   // set up the lock: active, empty rising, FIFO level 0
   task automatic arm(input bit dsel);
      drive(1, 1, 1, dsel, 0, 0);
      drive(1, 1, 1, dsel, 0, 1);
   endtask

   initial begin
      #1600000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'h5eed_0417);
      // R1 reset state
      fifo_level = 6'd5;
      #1;
      check(1'b1, "R1 during reset");
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      drive(1, 1, 1, 0, 7, 0);
      check(1'b1, "R1 after reset");

      // R4: small depth, release at 14, permit one cycle later
      arm(0);
      drive(1, 1, 1, 0, 5, 0);
      check(1'b0, "R3 locked with data");
      drive(1, 1, 1, 0, 13, 0);
      check(1'b0, "R4 level 13 keeps lock");
      drive(1, 1, 1, 0, 14, 0);
      check(1'b0, "R4 level 14 same cycle");
      drive(1, 1, 1, 0, 14, 0);
      check(1'b1, "R4 level 14 next cycle");
      // R8 drain stays open
      for (int k = 13; k >= 1; k--) begin
         drive(1, 1, 1, 0, k, 0);
         check(1'b1, "R8 draining");
      end
      drive(1, 1, 1, 0, 0, 0);
      check(1'b0, "R7 empty level");

      // R5: large depth
      arm(1);
      drive(1, 1, 1, 1, 14, 0);
      check(1'b0, "R5 level 14 keeps lock");
      drive(1, 1, 1, 1, 29, 0);
      check(1'b0, "R5 level 29 keeps lock");
      drive(1, 1, 1, 1, 30, 0);
      check(1'b0, "R5 level 30 same cycle");
      drive(1, 1, 1, 1, 30, 0);
      check(1'b1, "R5 level 30 next cycle");

      // R6: drop each enable while locked
      for (int w = 0; w < 3; w++) begin
         arm(0);
         drive(1, 1, 1, 0, 3, 0);
         check(1'b0, "R3 locked before disable");
         drive(w != 0, w != 1, w != 2, 0, 3, 0);
         check(1'b1, "R6 disable frees same cycle");
         drive(1, 1, 1, 0, 3, 0);
         check(1'b1, "R6 lock gone after re-enable");
      end

      // R2: inactive ignores empty edge
      drive(0, 1, 1, 0, 0, 0);
      drive(0, 1, 1, 0, 0, 1);
      drive(0, 1, 1, 0, 4, 1);
      check(1'b1, "R2 inactive no lock");

      // R9: enable while already empty, no edge
      drive(0, 1, 1, 0, 0, 1);
      drive(1, 1, 1, 0, 0, 1);
      drive(1, 1, 1, 0, 2, 1);
      check(1'b1, "R9 held empty no lock");
      drive(1, 1, 1, 0, 2, 1);
      check(1'b1, "R9 held empty still open");

      // R3: empty rise with level already met does not lock
      drive(1, 1, 1, 0, 20, 0);
      drive(1, 1, 1, 0, 20, 1);
      drive(1, 1, 1, 0, 5, 0);
      check(1'b1, "R3 release wins over set");

      // constrained random against the model
      for (int n = 0; n < 4000; n++) begin
         int lvl;
         bit en, ext, fon, dsel, emp;
         en   = ($urandom_range(0, 9) != 0);
         ext  = ($urandom_range(0, 19) != 0);
         fon  = ($urandom_range(0, 19) != 0);
         dsel = (n / 500) % 2 == 1;
         lvl  = int'(fifo_level) + $urandom_range(0, 4) - 2;
         if ($urandom_range(0, 29) == 0) lvl = 0;
         if (lvl < 0) lvl = 0;
         if (lvl > 32) lvl = 32;
         emp  = (lvl == 0) ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 15) == 0);
         drive(en, ext, fon, dsel, lvl, emp);
         check(f_permit(), model_tag());
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule